// File: doc/BRIEF.md
# Injected Conversion Context Queue

This block holds the conversion contexts that software programs for an injected channel group. Each context names how many conversions the group runs (one to four) and which of several hardware trigger lines launches it. Software pushes contexts through a single-cycle write port. The block keeps up to two of them in arrival order. The oldest one is the active context, and a read port shows it at all times.

While idle, the block watches only the trigger line that the active context selects. When that line pulses, the block issues a start-conversion pulse to the conversion engine for each conversion and counts the engine's done strobes. After the last done strobe it raises an end-of-sequence pulse and retires the active context. A drain-mode input sets what happens to the final context. With drain mode low, the context is kept and answers later triggers again. With drain mode high, the queue is left empty.

A context written while both slots are full is discarded. The discard sets a sticky overflow flag, which only software can clear, and produces a one-cycle interrupt request.

Top module: `inj_ctx_queue`

## Requirements
- R1: A write with `wr_en` high stores a context whose length is `wr_len`+1 conversions (`wr_len` 0..3 means 1..4) and whose trigger is `trig_in[wr_trig]`. `act_valid`, `act_len` and `act_trig` show the oldest stored context as it was written. When no context is stored, `act_valid` is 0 and `act_len` and `act_trig` read 0.
- R2: At most two contexts are stored. A write that arrives while two are stored, with no retirement in the same cycle, is discarded and leaves the stored contexts unchanged.
- R3: A discarded write sets `ovf_flag` and pulses `ovf_irq` for exactly one cycle, both on the clock edge that samples the write.
- R4: `ovf_flag` stays set until a cycle with `ovf_clr` high and no new discard. If a discard and `ovf_clr` occur in the same cycle, the flag stays set.
- R5: The clock edge that samples the final done strobe of a sequence raises `eos` for exactly one cycle. The same edge retires the active context and makes the next stored context active.
- R6: With `drain_mode` low, completing the sequence of the only stored context keeps that context active, and a later selected trigger runs it again.
- R7: With `drain_mode` high, completing the sequence of the only stored context empties the queue.
- R8: A sequence starts only on a high level of the trigger line the active context selects, sampled while idle. Other trigger lines, triggers during a running sequence and triggers while the queue is empty have no effect.
- R9: `soc` pulses for one cycle on the edge after the accepted trigger and on the edge after each done strobe that is not the last. A length of N gives exactly N pulses. A `conv_done` while idle is ignored.
- R10: A write in the same cycle as the final done strobe of a full queue is accepted: the retirement happens first and frees a slot.
- R11: A synchronous low level on `rst_n` empties the queue, clears `eos`, `soc`, `ovf_flag` and `ovf_irq`, and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Context write strobe |
| wr_len | input | 2 | Sequence length minus one for the written context |
| wr_trig | input | 2 | Trigger line index for the written context |
| drain_mode | input | 1 | 1: the last context is retired on completion; 0: it is kept |
| trig_in | input | 4 | Hardware trigger lines |
| conv_done | input | 1 | Per-conversion done strobe from the conversion engine |
| ovf_clr | input | 1 | Software clear for the overflow flag |
| soc | output | 1 | Start-conversion pulse |
| eos | output | 1 | End-of-sequence pulse |
| ovf_flag | output | 1 | Sticky queue-overflow flag |
| ovf_irq | output | 1 | One-cycle overflow interrupt request |
| act_valid | output | 1 | A context is active |
| act_len | output | 2 | Active context length minus one |
| act_trig | output | 2 | Active context trigger index |

## Verification
The bench sweeps every length, trigger index and drain setting. In each case it first drives every trigger line except the selected one, then raises the selected line again inside the gaps of the running sequence. A design that decodes the trigger index wrongly, or that restarts while a sequence runs, would emit extra or missing start pulses. A design with an off-by-one in the conversion counter would end the sequence one conversion early or late, and that shows up in where `eos` falls.

The bench also fills the queue and writes a third context. A design that overwrites a stored context instead of dropping the write would bring the dropped context up as active afterwards. Another case writes a context in the same cycle as a final done strobe. A design that handles the push before the retirement would report an overflow and lose that context.

// File: rtl/inj_ctx_pkg.sv
// Shared constants and types for the injected conversion context queue.
// Assumes a trigger count and maximum sequence length that are powers of two.
package inj_ctx_pkg;
    localparam int unsigned NUM_TRIG = 4;
    localparam int unsigned MAX_LEN  = 4;
    localparam int unsigned LEN_W    = (MAX_LEN  > 1) ? $clog2(MAX_LEN)  : 1;
    localparam int unsigned TRIG_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

    // One queued context: sequence length minus one and the trigger index.
    typedef struct packed {
        logic [LEN_W-1:0]  len_m1;
        logic [TRIG_W-1:0] trig_sel;
    } ctx_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_t;
endpackage

// File: rtl/inj_ctx_fifo.sv
// Context store: a shift queue of DEPTH slots, with slot 0 as the head.
// Applies a retirement (pop) before a push in the same cycle. With drain low,
// a pop never takes the last remaining context. A push into a full queue
// after the pop is dropped and reported through `dropped`.
module inj_ctx_fifo
    import inj_ctx_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  ctx_t push_ctx,
    input  logic pop_req,
    input  logic drain,
    output ctx_t head,
    output logic head_valid,
    output logic dropped
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    ctx_t [DEPTH-1:0] slot_q;
    ctx_t [DEPTH-1:0] slot_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_mid;
    logic [CNT_W-1:0] cnt_d;
    logic             do_pop;
    logic             accept;

    // Decide the pop first, then whether the push fits in what is left.
    always_comb begin
        do_pop  = pop_req && (cnt_q != '0) && ((cnt_q > CNT_W'(1)) || drain);
        cnt_mid = cnt_q - CNT_W'(do_pop);
        accept  = push && (cnt_mid < CNT_W'(DEPTH));
        dropped = push && !accept;
        cnt_d   = cnt_mid + CNT_W'(accept);
    end

    // Next value of each slot: shift down on a pop, then drop the push into the first free slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        ctx_t shifted;
        if (i < DEPTH - 1) begin : g_mid
            assign shifted = do_pop ? slot_q[i+1] : slot_q[i];
        end else begin : g_end
            assign shifted = slot_q[i];
        end
        assign slot_d[i] = (accept && (cnt_mid == CNT_W'(i))) ? push_ctx : shifted;
    end

    // Register the slots and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            cnt_q  <= '0;
        end else begin
            slot_q <= slot_d;
            cnt_q  <= cnt_d;
        end
    end

    assign head       = slot_q[0];
    assign head_valid = (cnt_q != '0);

    // R2
    depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cnt_q == CNT_W'(DEPTH) && !pop_req) |=> (cnt_q == CNT_W'(DEPTH) && $stable(head)));

    // R6
    keep_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && cnt_q == CNT_W'(1) && !drain && !push) |=> (cnt_q == CNT_W'(1) && $stable(head)));

    // R7
    drain_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && cnt_q == CNT_W'(1) && drain && !push) |=> (cnt_q == '0));

    // R10
    pop_then_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && cnt_q == CNT_W'(DEPTH) && push) |=> (cnt_q == CNT_W'(DEPTH)));
endmodule

// File: rtl/inj_seq_engine.sv
// Sequence engine: waits while idle for the trigger line that the active
// context selects, then issues one start pulse per conversion and counts
// done strobes up to the programmed length. Assumes the active context does
// not change while a sequence runs; it changes only on `seq_done`.
module inj_seq_engine
    import inj_ctx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctx_valid,
    input  ctx_t                ctx,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                conv_done,
    output logic                soc,
    output logic                seq_done
);
    eng_state_t       state_q;
    logic [LEN_W-1:0] conv_cnt_q;
    logic             soc_q;
    logic             fire;
    logic             step;

    // Classify this cycle: accepted trigger, intermediate done, or final done.
    always_comb begin
        fire     = (state_q == ENG_IDLE) && ctx_valid && trig_in[ctx.trig_sel];
        step     = (state_q == ENG_RUN) && conv_done && (conv_cnt_q != ctx.len_m1);
        seq_done = (state_q == ENG_RUN) && conv_done && (conv_cnt_q == ctx.len_m1);
    end

    // Advance the run state, the conversion counter and the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ENG_IDLE;
            conv_cnt_q <= '0;
            soc_q      <= 1'b0;
        end else begin
            soc_q <= fire || step;
            if (fire) begin
                state_q    <= ENG_RUN;
                conv_cnt_q <= '0;
            end else if (step) begin
                conv_cnt_q <= conv_cnt_q + LEN_W'(1);
            end else if (seq_done) begin
                state_q    <= ENG_IDLE;
                conv_cnt_q <= '0;
            end
        end
    end

    assign soc = soc_q;

    // R8
    empty_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_valid |=> !soc_q);

    // R9
    run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_RUN && !conv_done) |=> !soc_q);

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_RUN) |-> (conv_cnt_q <= ctx.len_m1));

    // R5
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (state_q == ENG_IDLE && !soc_q));
endmodule

// File: rtl/inj_status_flags.sv
// Status flags: a one-cycle end-of-sequence pulse, a sticky overflow flag that
// only software clears, and a one-cycle overflow interrupt. Assumes that
// `dropped` and `seq_done` are single-cycle events.
module inj_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic seq_done,
    input  logic dropped,
    input  logic ovf_clr,
    output logic eos,
    output logic ovf_flag,
    output logic ovf_irq
);
    logic eos_q;
    logic ovf_q;
    logic irq_q;

    // Update the flags; a new discard takes priority over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eos_q <= 1'b0;
            ovf_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            eos_q <= seq_done;
            irq_q <= dropped;
            if (dropped) begin
                ovf_q <= 1'b1;
            end else if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
        end
    end

    assign eos      = eos_q;
    assign ovf_flag = ovf_q;
    assign ovf_irq  = irq_q;

    // R3
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> (ovf_q && irq_q));

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);

    // R4
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !dropped) |=> !ovf_q);

    // R5
    eos_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> eos_q);
endmodule

// File: rtl/inj_ctx_queue.sv
// Injected conversion context queue, top level. Connects the context store,
// the sequence engine and the status flags. The active context is the head
// of the store; a completed sequence retires it according to `drain_mode`.
module inj_ctx_queue
    import inj_ctx_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [TRIG_W-1:0] wr_trig,
    input  logic              drain_mode,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic              conv_done,
    input  logic              ovf_clr,
    output logic              soc,
    output logic              eos,
    output logic              ovf_flag,
    output logic              ovf_irq,
    output logic              act_valid,
    output logic [LEN_W-1:0]  act_len,
    output logic [TRIG_W-1:0] act_trig
);
    ctx_t wr_ctx;
    ctx_t head;
    logic head_valid;
    logic dropped;
    logic seq_done;

    assign wr_ctx.len_m1   = wr_len;
    assign wr_ctx.trig_sel = wr_trig;

    inj_ctx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_en),
        .push_ctx   (wr_ctx),
        .pop_req    (seq_done),
        .drain      (drain_mode),
        .head       (head),
        .head_valid (head_valid),
        .dropped    (dropped)
    );

    inj_seq_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctx_valid (head_valid),
        .ctx       (head),
        .trig_in   (trig_in),
        .conv_done (conv_done),
        .soc       (soc),
        .seq_done  (seq_done)
    );

    inj_status_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_done (seq_done),
        .dropped  (dropped),
        .ovf_clr  (ovf_clr),
        .eos      (eos),
        .ovf_flag (ovf_flag),
        .ovf_irq  (ovf_irq)
    );

    // Present the active context, reading zero when the store is empty.
    always_comb begin
        act_valid = head_valid;
        act_len   = head_valid ? head.len_m1   : '0;
        act_trig  = head_valid ? head.trig_sel : '0;
    end

    // R1
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid |-> (act_len == '0 && act_trig == '0));

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!act_valid && !soc && !eos && !ovf_flag && !ovf_irq));
endmodule

// File: tb/inj_ctx_queue_test.sv
module inj_ctx_queue_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_len;
    logic [1:0] wr_trig;
    logic       drain_mode;
    logic [3:0] trig_in;
    logic       conv_done;
    logic       ovf_clr;
    logic       soc, eos, ovf_flag, ovf_irq, act_valid;
    logic [1:0] act_len, act_trig;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    inj_ctx_queue uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_len(wr_len), .wr_trig(wr_trig),
        .drain_mode(drain_mode), .trig_in(trig_in), .conv_done(conv_done), .ovf_clr(ovf_clr),
        .soc(soc), .eos(eos), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq),
        .act_valid(act_valid), .act_len(act_len), .act_trig(act_trig)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_len = '0; wr_trig = '0;
        trig_in = '0; conv_done = 1'b0; ovf_clr = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_ctx(input int len, input int sel);
        wr_en = 1'b1; wr_len = 2'(len - 1); wr_trig = 2'(sel);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_active(input string req, input int len, input int sel);
        check({req, " valid"}, act_valid, 1);
        check({req, " len"}, act_len, len - 1);
        check({req, " trig"}, act_trig, sel);
    endtask

    // Drives every trigger line except the selected one and expects no start pulse (R8).
    task automatic wrong_triggers(input int sel);
        trig_in = 4'hF & ~(4'h1 << sel);
        @(negedge clk);
        trig_in = '0;
        check("R8 unselected trigger", soc, 0);
    endtask

    // Runs one full sequence; optionally writes a context with the final done strobe (R10).
    task automatic run_seq(input int len, input int sel, input bit wr_last,
                           input int wlen, input int wsel);
        trig_in = 4'h1 << sel;
        @(negedge clk);
        trig_in = '0;
        for (int k = 0; k < len; k++) begin
            check("R9 start pulse", soc, 1);
            check("R5 no early eos", eos, 0);
            trig_in = 4'h1 << sel;
            @(negedge clk);
            trig_in = '0;
            check("R8 trigger while running", soc, 0);
            conv_done = 1'b1;
            if (wr_last && k == len - 1) begin
                wr_en = 1'b1; wr_len = 2'(wlen - 1); wr_trig = 2'(wsel);
            end
            @(negedge clk);
            conv_done = 1'b0;
            wr_en = 1'b0;
        end
        check("R5 eos raised", eos, 1);
        check("R9 no extra start", soc, 0);
        @(negedge clk);
        check("R5 eos one cycle", eos, 0);
    endtask

    initial begin
        drain_mode = 1'b0;
        do_reset();
        // R11 reset state
        check("R11 act_valid", act_valid, 0);
        check("R11 soc", soc, 0);
        check("R11 eos", eos, 0);
        check("R11 ovf_flag", ovf_flag, 0);
        check("R1 empty len", act_len, 0);
        check("R1 empty trig", act_trig, 0);
        // R8 triggers on an empty queue
        trig_in = 4'hF;
        @(negedge clk);
        trig_in = '0;
        check("R8 empty trigger", soc, 0);
        // R9 done strobe while idle
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        check("R9 idle done soc", soc, 0);
        check("R9 idle done eos", eos, 0);

        // Sweep over all drain settings, lengths and trigger lines.
        for (int m = 0; m < 2; m++) begin
            for (int len = 1; len <= 4; len++) begin
                for (int sel = 0; sel < 4; sel++) begin
                    drain_mode = m[0];
                    do_reset();
                    write_ctx(len, sel);
                    expect_active("R1", len, sel);
                    wrong_triggers(sel);
                    // R9 idle done is ignored, so the count below still holds
                    conv_done = 1'b1;
                    @(negedge clk);
                    conv_done = 1'b0;
                    check("R9 idle done", soc, 0);
                    run_seq(len, sel, 1'b0, 1, 0);
                    if (m == 0) begin
                        expect_active("R6 kept", len, sel);
                        run_seq(len, sel, 1'b0, 1, 0);
                        expect_active("R6 kept again", len, sel);
                    end else begin
                        check("R7 drained", act_valid, 0);
                        check("R7 drained len", act_len, 0);
                    end
                end
            end
        end

        // Overflow: third write dropped; the queue is unchanged.
        drain_mode = 1'b1;
        do_reset();
        write_ctx(2, 1);
        check("R3 no ovf", ovf_flag, 0);
        write_ctx(3, 2);
        check("R2 second accepted", ovf_flag, 0);
        write_ctx(4, 3);
        check("R3 ovf set", ovf_flag, 1);
        check("R3 irq", ovf_irq, 1);
        expect_active("R2 head unchanged", 2, 1);
        @(negedge clk);
        check("R3 irq one cycle", ovf_irq, 0);
        check("R4 sticky", ovf_flag, 1);
        run_seq(2, 1, 1'b0, 1, 0);
        expect_active("R5 next active", 3, 2);
        run_seq(3, 2, 1'b0, 1, 0);
        check("R2 dropped not stored", act_valid, 0);
        check("R4 still set", ovf_flag, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check("R4 cleared", ovf_flag, 0);

        // Discard and clear in the same cycle: the flag stays set.
        write_ctx(1, 0);
        write_ctx(1, 1);
        ovf_clr = 1'b1;
        write_ctx(1, 2);
        ovf_clr = 1'b0;
        check("R4 set beats clear", ovf_flag, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;

        // Write on the final done of a full queue is accepted.
        do_reset();
        write_ctx(1, 3);
        write_ctx(2, 0);
        run_seq(1, 3, 1'b1, 4, 2);
        check("R10 no overflow", ovf_flag, 0);
        expect_active("R10 next", 2, 0);
        run_seq(2, 0, 1'b0, 1, 0);
        expect_active("R10 written stored", 4, 2);

        // Reset in the middle of a sequence.
        trig_in = 4'h4;
        @(negedge clk);
        trig_in = '0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 mid reset soc", soc, 0);
        check("R11 mid reset empty", act_valid, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule